// File: doc/BRIEF.md
# Multi-Core Debug Halt Interconnect

This block ties together the debug halt signals of a cluster of processor cores, whose count is a parameter. Each core owns a four-bit enable register. One bit lets the core accept break requests from its peers. One bit lets the core's own halt reach its peers. One bit lets the core be stalled by peers. One bit lets the core's debug state be seen as a stall source. When a core signals debug entry and its outgoing break is enabled, every other core that accepts breaks gets a break request on the next cycle. That request stays up until the target core reports its own debug entry, or until a global clear strobe arrives.

The block also keeps a debug-mode flag for each core. The flag is set by an entry pulse and cleared by a leave pulse. The block drives a stall line to each core that accepts stalls whenever another core is in debug mode and has its debug-state output enabled.

A debugger programs the enables through a small write port. It can write the four bits directly, or it can use one of three presets that write a whole group of bits at once. Reset clears every enable, so each core starts out isolated from the others.

Top module: `dbg_xnet`

## Requirements
- R1: After reset all enables are zero and every break request, stall line and debug-mode flag reads 0.
- R2: A raw write (mode 00) loads the selected core's enables from the write data, with bit 0 as break-accept, bit 1 as break-send, bit 2 as stall-accept and bit 3 as debug-state-out. The new value governs behaviour from the next cycle on.
- R3: Preset mode 01 clears all four enables of the selected core, so that core neither sends nor receives any signal.
- R4: Preset mode 10 sets break-accept and break-send on the selected core and clears the two stall enables.
- R5: Preset mode 11 sets stall-accept and debug-state-out on the selected core and clears the two break enables.
- R6: A write whose select is not below the core count changes no enable.
- R7: A debug-entry pulse on core j with break-send set raises, one cycle later, the break request of every other core that has break-accept set.
- R8: A core never receives a break request caused by its own debug entry.
- R9: A break request stays asserted until the target core pulses debug entry. That entry drops the request on the next cycle, and it takes priority over a new source arriving in the same cycle.
- R10: The clear strobe drops all break requests on the next cycle, and it takes priority over new sources and held requests.
- R11: A core's debug-mode flag is set one cycle after its entry pulse and cleared one cycle after its leave pulse. When both pulses arrive together, entry wins.
- R12: The stall line of core i is high exactly when core i has stall-accept set and some other core has both its debug-mode flag and debug-state-out set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Enable register write strobe |
| cfg_sel | input | SEL_W | Core index to write |
| cfg_mode | input | 2 | 00 raw, 01 none, 10 break in/out, 11 run-stall |
| cfg_wdata | input | 4 | Raw enable bits (used in mode 00) |
| dbg_entry | input | NUM_CORES | Per-core debug-entry pulse |
| dbg_leave | input | NUM_CORES | Per-core debug-exit pulse |
| brk_clr | input | 1 | Clears all pending break requests |
| brk_req | output | NUM_CORES | Per-core break request |
| stall_req | output | NUM_CORES | Per-core stall line |
| dbg_stat | output | NUM_CORES | Per-core debug-mode flag |

## Verification
The hardest situation to reach from the ports is a collision in one cycle. A core's own entry pulse, or the clear strobe, arrives in the same cycle as a fresh break source from a peer, and priority decides the result. The stimulus first programs asymmetric enables, with one core that only sends and others that only accept. It then fires entry pulses on several cores together, sometimes alongside the clear strobe, so that the acknowledge and clear rules each have a competing request to override. The stall path is driven the same way. Entry and leave pulses are overlapped while the debug-state-out and stall-accept bits are split across different cores.

// File: rtl/dbgx_pkg.sv
package dbgx_pkg;

   typedef struct packed {
      logic dmo;   // bit 3: debug state visible as stall source
      logic rsi;   // bit 2: accepts stall from peers
      logic bo;    // bit 1: halt propagates to peers
      logic bi;    // bit 0: accepts break from peers
   } xcfg_t;

   typedef enum logic [1:0] {
      MODE_RAW   = 2'b00,
      MODE_NONE  = 2'b01,
      MODE_BRKIO = 2'b10,
      MODE_STALL = 2'b11
   } xmode_e;

   function automatic xcfg_t cfg_decode(input xmode_e m, input logic [3:0] raw);
      xcfg_t r;
      case (m)
         MODE_RAW:   r = xcfg_t'(raw);
         MODE_NONE:  r = '0;
         MODE_BRKIO: r = '{dmo: 1'b0, rsi: 1'b0, bo: 1'b1, bi: 1'b1};
         default:    r = '{dmo: 1'b1, rsi: 1'b1, bo: 1'b0, bi: 1'b0};
      endcase
      return r;
   endfunction

endpackage

// File: rtl/dbgx_cfg_bank.sv
module dbgx_cfg_bank
   import dbgx_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int SEL_W     = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  we,
   input  logic [SEL_W-1:0]      sel,
   input  logic [1:0]            mode,
   input  logic [3:0]            wdata,
   output xcfg_t [NUM_CORES-1:0] cfg_o
);

   xcfg_t wr_val;
   assign wr_val = cfg_decode(xmode_e'(mode), wdata);

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      xcfg_t cfg_q;
      logic  hit;
      assign hit = we && (sel == SEL_W'(c));

      always_ff @(posedge clk) begin
         if (!rst_n)   cfg_q <= '0;
         else if (hit) cfg_q <= wr_val;
      end
      assign cfg_o[c] = cfg_q;
   end

   AST_PRESET_NONE: assert property (@(posedge clk) disable iff (!rst_n)
      (we && mode == 2'b01 && int'(sel) < NUM_CORES) |=> (cfg_o[$past(sel)] == '0)); // R3
   AST_BAD_SEL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (we && int'(sel) >= NUM_CORES) |=> $stable(cfg_o)); // R6

endmodule

// File: rtl/dbgx_status.sv
module dbgx_status #(
   parameter int NUM_CORES = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_CORES-1:0] entry,
   input  logic [NUM_CORES-1:0] leave,
   output logic [NUM_CORES-1:0] in_dbg_o
);

   logic [NUM_CORES-1:0] in_q;

   always_ff @(posedge clk) begin
      if (!rst_n) in_q <= '0;
      else        in_q <= entry | (in_q & ~leave);
   end
   assign in_dbg_o = in_q;

   for (genvar i = 0; i < NUM_CORES; i++) begin : g_chk
      AST_ENTRY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
         entry[i] |=> in_q[i]); // R11
      AST_LEAVE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         (leave[i] && !entry[i]) |=> !in_q[i]); // R11
   end

endmodule

// File: rtl/dbgx_brk_fanout.sv
module dbgx_brk_fanout #(
   parameter int NUM_CORES = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_CORES-1:0] entry,
   input  logic [NUM_CORES-1:0] bi,
   input  logic [NUM_CORES-1:0] bo,
   input  logic                 clr,
   output logic [NUM_CORES-1:0] brk_o
);

   logic [NUM_CORES-1:0] senders;
   logic [NUM_CORES-1:0] brk_q;

   assign senders = entry & bo;

   for (genvar i = 0; i < NUM_CORES; i++) begin : g_tgt
      localparam logic [NUM_CORES-1:0] OTHERS = ~(NUM_CORES'(1) << i);
      logic src;
      assign src = bi[i] & (|(senders & OTHERS));

      always_ff @(posedge clk) begin
         if (!rst_n)        brk_q[i] <= 1'b0;
         else if (clr)      brk_q[i] <= 1'b0;
         else if (entry[i]) brk_q[i] <= 1'b0;
         else if (src)      brk_q[i] <= 1'b1;
      end

      AST_BREAK_FANS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
         (bi[i] && |(entry & bo & OTHERS) && !clr && !entry[i]) |=> brk_q[i]); // R7
      AST_NO_SELF_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(brk_q[i]) |-> $past(|(entry & bo & OTHERS))); // R8
      AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
         entry[i] |=> !brk_q[i]); // R9
      AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
         (brk_q[i] && !entry[i] && !clr) |=> brk_q[i]); // R9
   end

   AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (brk_q == '0)); // R10

   assign brk_o = brk_q;

endmodule

// File: rtl/dbgx_stall_fanout.sv
module dbgx_stall_fanout #(
   parameter int NUM_CORES = 4
) (
   input  logic [NUM_CORES-1:0] in_dbg,
   input  logic [NUM_CORES-1:0] dmo,
   input  logic [NUM_CORES-1:0] rsi,
   output logic [NUM_CORES-1:0] stall_o
);

   logic [NUM_CORES-1:0] sources;
   assign sources = in_dbg & dmo;

   for (genvar i = 0; i < NUM_CORES; i++) begin : g_tgt
      localparam logic [NUM_CORES-1:0] OTHERS = ~(NUM_CORES'(1) << i);
      assign stall_o[i] = rsi[i] & (|(sources & OTHERS));
   end

endmodule

// File: rtl/dbg_xnet.sv
module dbg_xnet
   import dbgx_pkg::*;
#(
   parameter  int NUM_CORES = 4,
   localparam int SEL_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [SEL_W-1:0]     cfg_sel,
   input  logic [1:0]           cfg_mode,
   input  logic [3:0]           cfg_wdata,
   input  logic [NUM_CORES-1:0] dbg_entry,
   input  logic [NUM_CORES-1:0] dbg_leave,
   input  logic                 brk_clr,
   output logic [NUM_CORES-1:0] brk_req,
   output logic [NUM_CORES-1:0] stall_req,
   output logic [NUM_CORES-1:0] dbg_stat
);

   if (NUM_CORES < 2 || NUM_CORES > 64) begin : g_bad_cores
      $error("dbg_xnet: NUM_CORES must be in 2..64");
   end

   xcfg_t [NUM_CORES-1:0] cfg;
   logic  [NUM_CORES-1:0] bi_v, bo_v, rsi_v, dmo_v;
   logic  [NUM_CORES-1:0] in_dbg;

   dbgx_cfg_bank #(.NUM_CORES(NUM_CORES), .SEL_W(SEL_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
      .mode(cfg_mode), .wdata(cfg_wdata), .cfg_o(cfg)
   );

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_split
      assign bi_v[c]  = cfg[c].bi;
      assign bo_v[c]  = cfg[c].bo;
      assign rsi_v[c] = cfg[c].rsi;
      assign dmo_v[c] = cfg[c].dmo;
   end

   dbgx_status #(.NUM_CORES(NUM_CORES)) u_stat (
      .clk(clk), .rst_n(rst_n), .entry(dbg_entry), .leave(dbg_leave),
      .in_dbg_o(in_dbg)
   );

   dbgx_brk_fanout #(.NUM_CORES(NUM_CORES)) u_brk (
      .clk(clk), .rst_n(rst_n), .entry(dbg_entry), .bi(bi_v), .bo(bo_v),
      .clr(brk_clr), .brk_o(brk_req)
   );

   dbgx_stall_fanout #(.NUM_CORES(NUM_CORES)) u_stall (
      .in_dbg(in_dbg), .dmo(dmo_v), .rsi(rsi_v), .stall_o(stall_req)
   );

   assign dbg_stat = in_dbg;

   AST_RESET_ISOLATED: assert property (@(posedge clk)
      $past(!rst_n) |-> (cfg == '0 && brk_req == '0 && in_dbg == '0)); // R1

endmodule

// File: tb/dbg_xnet_tb_top.sv
`timescale 1ns/1ps
module dbg_xnet_tb_top;

   localparam int N = 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cfg_we = 1'b0;
   logic [1:0]   cfg_sel = '0;
   logic [1:0]   cfg_mode = '0;
   logic [3:0]   cfg_wdata = '0;
   logic [N-1:0] dbg_entry = '0;
   logic [N-1:0] dbg_leave = '0;
   logic         brk_clr = 1'b0;
   logic [N-1:0] brk_req, stall_req, dbg_stat;

   always #2 clk = ~clk;

   dbg_xnet #(.NUM_CORES(N)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_mode(cfg_mode), .cfg_wdata(cfg_wdata), .dbg_entry(dbg_entry),
      .dbg_leave(dbg_leave), .brk_clr(brk_clr), .brk_req(brk_req),
      .stall_req(stall_req), .dbg_stat(dbg_stat)
   );

   typedef struct {
      logic [N-1:0] brk;
      logic [N-1:0] stall;
      logic [N-1:0] stat;
      string        tag;
   } exp_t;

   exp_t exp_q[$];
   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   // reference state
   logic [3:0]   m_cfg [N];
   logic [N-1:0] m_st  = '0;
   logic [N-1:0] m_brk = '0;

   task automatic step(input logic we, input logic [1:0] sel, input logic [1:0] mode,
                       input logic [3:0] wd, input logic [N-1:0] en, input logic [N-1:0] lv,
                       input logic clr, input string tag);
      logic [N-1:0] bo, nb, nst, ns;
      exp_t e;
      @(negedge clk);
      cfg_we = we; cfg_sel = sel; cfg_mode = mode; cfg_wdata = wd;
      dbg_entry = en; dbg_leave = lv; brk_clr = clr;
      for (int i = 0; i < N; i++) bo[i] = m_cfg[i][1];
      for (int i = 0; i < N; i++) begin
         logic src;
         src = 1'b0;
         for (int j = 0; j < N; j++) if (j != i && en[j] && bo[j]) src = 1'b1;
         src = src & m_cfg[i][0];
         nb[i] = clr ? 1'b0 : (en[i] ? 1'b0 : (m_brk[i] | src));
      end
      nst = en | (m_st & ~lv);
      if (we && int'(sel) < N) begin
         case (mode)
            2'b00: m_cfg[sel] = wd;
            2'b01: m_cfg[sel] = 4'b0000;
            2'b10: m_cfg[sel] = 4'b0011;
            default: m_cfg[sel] = 4'b1100;
         endcase
      end
      for (int i = 0; i < N; i++) begin
         logic s;
         s = 1'b0;
         for (int j = 0; j < N; j++) if (j != i && nst[j] && m_cfg[j][3]) s = 1'b1;
         ns[i] = s & m_cfg[i][2];
      end
      m_brk = nb; m_st = nst;
      e.brk = nb; e.stall = ns; e.stat = nst; e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic idle(input string tag);
      step(1'b0, 2'd0, 2'd0, 4'd0, '0, '0, 1'b0, tag);
   endtask

   // monitor: compares one expected item per clock, away from the edge
   always @(posedge clk) begin
      #1;
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         n_cmp++;
         if (brk_req !== e.brk || stall_req !== e.stall || dbg_stat !== e.stat) begin
            n_bad++;
            $display("FAIL %s: brk/stall/stat actual %b/%b/%b expected %b/%b/%b",
                     e.tag, brk_req, stall_req, dbg_stat, e.brk, e.stall, e.stat);
         end
      end
   end

   initial begin
      for (int i = 0; i < N; i++) m_cfg[i] = 4'b0000;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      n_cmp++;
      if (brk_req !== '0 || stall_req !== '0 || dbg_stat !== '0) begin
         n_bad++;
         $display("FAIL R1: brk/stall/stat actual %b/%b/%b expected 000/000/000",
                  brk_req, stall_req, dbg_stat);
      end
      step(1'b0, 2'd0, 2'd0, 4'd0, 3'b111, '0, 1'b0, "R1 isolated after reset");
      step(1'b0, 2'd0, 2'd0, 4'd0, '0, 3'b111, 1'b0, "R11 leave clears");
      // R2: raw writes, core0 send only, core1 accept only
      step(1'b1, 2'd0, 2'b00, 4'b0010, '0, '0, 1'b0, "R2 raw write core0");
      step(1'b1, 2'd1, 2'b00, 4'b0001, '0, '0, 1'b0, "R2 raw write core1");
      step(1'b0, 2'd0, 2'd0, 4'd0, 3'b001, '0, 1'b0, "R7 core0 halt breaks core1");
      idle("R9 request held");
      step(1'b0, 2'd0, 2'd0, 4'd0, 3'b010, '0, 1'b0, "R9 core1 entry acks");
      step(1'b0, 2'd0, 2'd0, 4'd0, '0, 3'b011, 1'b0, "R11 leave both");
      // R4: break in/out on all cores
      step(1'b1, 2'd0, 2'b10, 4'd0, '0, '0, 1'b0, "R4 preset core0");
      step(1'b1, 2'd1, 2'b10, 4'd0, '0, '0, 1'b0, "R4 preset core1");
      step(1'b1, 2'd2, 2'b10, 4'd0, '0, '0, 1'b0, "R4 preset core2");
      step(1'b0, 2'd0, 2'd0, 4'd0, 3'b010, '0, 1'b0, "R8 core1 halt, no self break");
      step(1'b0, 2'd0, 2'd0, 4'd0, 3'b001, '0, 1'b1, "R10 clear beats new source");
      step(1'b0, 2'd0, 2'd0, 4'd0, 3'b101, '0, 1'b0, "R9 ack beats new source");
      step(1'b0, 2'd0, 2'd0, 4'd0, '0, 3'b111, 1'b1, "R10 clear held requests");
      // R3: isolate core1
      step(1'b1, 2'd1, 2'b01, 4'd0, '0, '0, 1'b0, "R3 preset none core1");
      step(1'b0, 2'd0, 2'd0, 4'd0, 3'b001, '0, 1'b0, "R3 core1 gets no break");
      step(1'b0, 2'd0, 2'd0, 4'd0, 3'b010, '0, 1'b0, "R3 core1 sends no break");
      // R6: out-of-range select
      step(1'b1, 2'd3, 2'b10, 4'd0, '0, 3'b111, 1'b1, "R6 bad select write");
      step(1'b0, 2'd0, 2'd0, 4'd0, 3'b001, '0, 1'b0, "R6 core1 still isolated");
      step(1'b0, 2'd0, 2'd0, 4'd0, '0, 3'b111, 1'b1, "R10 clear");
      // R5 / R12: stall network
      step(1'b1, 2'd0, 2'b11, 4'd0, '0, '0, 1'b0, "R5 preset run-stall core0");
      step(1'b1, 2'd1, 2'b11, 4'd0, '0, '0, 1'b0, "R5 preset run-stall core1");
      step(1'b0, 2'd0, 2'd0, 4'd0, 3'b001, '0, 1'b0, "R12 core0 debug stalls core1");
      step(1'b0, 2'd0, 2'd0, 4'd0, 3'b010, 3'b010, 1'b0, "R11 entry beats leave");
      step(1'b0, 2'd0, 2'd0, 4'd0, '0, 3'b001, 1'b0, "R12 core0 leaves");
      step(1'b1, 2'd2, 2'b00, 4'b0100, '0, '0, 1'b0, "R2 raw stall-accept core2");
      step(1'b0, 2'd0, 2'd0, 4'd0, 3'b001, 3'b010, 1'b0, "R12 core2 stalled by core0");
      step(1'b1, 2'd0, 2'b00, 4'b0100, '0, '0, 1'b0, "R12 core0 dmo off drops stall");
      step(1'b0, 2'd0, 2'd0, 4'd0, 3'b010, '0, 1'b0, "R12 core1 source");
      idle("R12 final");
      idle("drain");
      @(negedge clk);
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule